// File: doc/BRIEF.md
# Converter Serial Result Port

This block is the digital serial readout of a 16-bit successive-approximation converter. A conversion stub (or the analog core) pulses a start strobe, and later a done strobe that comes with the parallel result. On the done strobe the port captures the result into a shift register, optionally turning it into two's complement, and sends it out MSB first on a single data line.

Two serial modes are supported. In slave mode the host supplies the bit clock. The port chooses the update edge from a polarity input. It chains a downstream device's data in behind its own bits. It flags a read that a newer result overtook. In master mode the port makes the bit clock from the system clock and marks the frame with a sync signal of selectable polarity. A read-mode input chooses whether the frame goes out during the next conversion or right after the current one finishes. Chip select and read enable must both be low for the data line to carry anything. All external host pins pass through two-flop synchronizers.

Top module: `sar_serial_port`

## Requirements
- R1: After reset, busy, sdout, sclkOut and rdError are 0, and syncOut sits at its inactive level, which equals invSync.
- R2: A convStart pulse drives busy high one clock later. busy stays high until a convDone pulse, which clears it one clock later. In the same clock the result is captured for shifting.
- R3: sdout is 0 unless the synchronized csN and rdN are both low. External SCLK edges that arrive while csN is high are ignored and do not shift the data.
- R4: Data leaves MSB first. With useTwos = 0 the captured word equals result. With useTwos = 1, bit 15 is inverted and bits 14..0 are unchanged.
- R5: In slave mode with invSclk = 0, the data advances one bit on each external rising edge. With invSclk = 1 it advances on each falling edge. The opposite edge never moves it.
- R6: In slave mode, the level on sdinRdc at the k-th update edge appears on sdout after update edge k+15. So the bits that follow the 16 result bits are the chained input.
- R7: In slave mode, if a convDone arrives after 1 to 15 update edges of the current word, rdError is high for exactly one clock and the new result replaces the old one. A convDone after a read of 16 or more edges raises no error.
- R8: In master mode each frame has exactly 16 sclkOut periods of 2*SCLK_HALF clocks. sclkOut is low outside frames. sdout changes only on sclkOut falling edges, so each bit is valid at the following rising edge.
- R9: In master mode syncOut equals !invSync for the whole frame and invSync otherwise.
- R10: In master mode, with sdinRdc = 0 a frame starts at convDone and sends the new result. With sdinRdc = 1 a frame starts at convStart and sends the previously captured result, and convDone starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| convStart | input | 1 | One-clock conversion start strobe |
| convDone | input | 1 | One-clock conversion complete strobe |
| result | input | 16 | Conversion result, valid with convDone |
| useTwos | input | 1 | 1 = two's complement output, 0 = offset binary |
| masterMode | input | 1 | 1 = port makes the bit clock, 0 = host supplies it |
| invSclk | input | 1 | Slave update-edge select |
| invSync | input | 1 | Master sync polarity select |
| sdinRdc | input | 1 | Slave: chained data in; master: read-during-conversion select |
| csN | input | 1 | Active-low chip select, gates external SCLK |
| rdN | input | 1 | Active-low read enable |
| sclkIn | input | 1 | External bit clock (slave mode) |
| sclkOut | output | 1 | Generated bit clock (master mode) |
| sdout | output | 1 | Serial data out |
| syncOut | output | 1 | Master frame marker |
| busy | output | 1 | Conversion in progress |
| rdError | output | 1 | Overrun read pulse (slave mode) |

## Verification
busy and the captured word respond in the clock after a strobe. Every external pin (csN, rdN, sclkIn, sdinRdc) takes three clocks to act: two synchronizer stages plus the edge register. The bench therefore drives strobes on falling clock edges and checks busy on the next falling edge. After each change of an external pin it waits six clocks before sampling sdout. In master mode sdout is sampled 1 ns after each sclkOut rise, which lies in the middle of a clock phase. Frame length is counted by a monitor on sclkOut rises, and rdError pulses are counted clock by clock, so error width and count come straight from the ports.

// File: rtl/sps_pkg.sv
package sps_pkg;
  // strobes from control to the shift datapath
  typedef struct packed {
    logic load;     // capture a new result
    logic shift;    // advance one bit
    logic shiftIn;  // bit entering at the LSB
    logic outEn;    // data line enabled
  } spsStrobe_t;
endpackage

// File: rtl/sps_sync.sv
module sps_sync #(
  parameter int WIDTH = 4,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] meta;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta    <= RST_VAL;
      syncOut <= RST_VAL;
    end else begin
      meta    <= asyncIn;
      syncOut <= meta;
    end
  end
endmodule

// File: rtl/sps_ctrl.sv
module sps_ctrl
  import sps_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int SCLK_HALF = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       convStart,
  input  logic       convDone,
  input  logic       masterMode,
  input  logic       invSclk,
  input  logic       invSync,
  input  logic       sclkIn,
  input  logic       csN,
  input  logic       rdN,
  input  logic       sdinRdc,
  output spsStrobe_t strobe,
  output logic       busy,
  output logic       sclkOut,
  output logic       syncOut,
  output logic       rdError
);
  localparam int CNT_W  = $clog2(DATA_W + 1);
  localparam int HALF_W = (SCLK_HALF < 2) ? 1 : $clog2(SCLK_HALF + 1);
  localparam logic [CNT_W-1:0]  FULL_CNT = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [HALF_W-1:0] HALF_END = HALF_W'(SCLK_HALF - 1);

  // bit order: {sdinRdc, rdN, csN, sclkIn}; selects rest high
  logic [3:0] syncd;
  sps_sync #(.WIDTH(4), .RST_VAL(4'b0110)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({sdinRdc, rdN, csN, sclkIn}),
    .syncOut (syncd)
  );

  logic sclkS, csS, rdS, sdinS, sclkPrev;
  assign sclkS = syncd[0];
  assign csS   = syncd[1];
  assign rdS   = syncd[2];
  assign sdinS = syncd[3];

  logic extRise, extFall, updEdge;
  assign extRise = sclkS & ~sclkPrev;
  assign extFall = ~sclkS & sclkPrev;
  assign updEdge = !masterMode && !csS && (invSclk ? extFall : extRise);

  logic [CNT_W-1:0]  slvCnt, bitCnt;
  logic [HALF_W-1:0] halfCnt;
  logic busyReg, frameActive, sclkReg, rdErrReg;
  logic readOpen, frameStart, halfWrap, mstShift;

  assign readOpen   = (slvCnt != '0) && (slvCnt != FULL_CNT);
  assign frameStart = masterMode && !frameActive && (sdinS ? convStart : convDone);
  assign halfWrap   = frameActive && (halfCnt == HALF_END);
  assign mstShift   = halfWrap && sclkReg;

  always_comb begin
    strobe.load    = convDone;
    strobe.shift   = updEdge | mstShift;
    strobe.shiftIn = masterMode ? 1'b0 : sdinS;
    strobe.outEn   = !csS && !rdS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyReg  <= 1'b0;
      sclkPrev <= 1'b0;
      slvCnt   <= '0;
      rdErrReg <= 1'b0;
    end else begin
      sclkPrev <= sclkS;
      rdErrReg <= !masterMode && convDone && readOpen;
      if (convDone)       busyReg <= 1'b0;
      else if (convStart) busyReg <= 1'b1;
      if (convDone)                            slvCnt <= '0;
      else if (updEdge && slvCnt != FULL_CNT)  slvCnt <= slvCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameActive <= 1'b0;
      sclkReg     <= 1'b0;
      halfCnt     <= '0;
      bitCnt      <= '0;
    end else if (frameStart) begin
      frameActive <= 1'b1;
      sclkReg     <= 1'b0;
      halfCnt     <= '0;
      bitCnt      <= '0;
    end else if (frameActive) begin
      if (halfWrap) begin
        halfCnt <= '0;
        sclkReg <= ~sclkReg;
        if (sclkReg) begin
          bitCnt <= bitCnt + CNT_W'(1);
          if (bitCnt == LAST_BIT) frameActive <= 1'b0;
        end
      end else begin
        halfCnt <= halfCnt + HALF_W'(1);
      end
    end
  end

  assign busy    = busyReg;
  assign sclkOut = sclkReg;
  assign syncOut = (masterMode & frameActive) ^ invSync;
  assign rdError = rdErrReg;

  // R2: start strobe raises busy
  p_busy_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    convStart && !convDone |=> busy);
  // R2: done strobe clears busy
  p_busy_clr_r2: assert property (@(posedge clk) disable iff (!rstN)
    convDone |=> !busy);
  // R8: generated clock idles low outside a frame
  p_sclk_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !frameActive |-> !sclkOut);
  // R8: never more than DATA_W bits per frame
  p_bitcnt_r8: assert property (@(posedge clk) disable iff (!rstN)
    frameActive |-> bitCnt < FULL_CNT);
  // R7: error flag lasts one clock
  p_err_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    rdError |=> !rdError);
endmodule

// File: rtl/sps_datapath.sv
module sps_datapath
  import sps_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  spsStrobe_t        strobe,
  input  logic [DATA_W-1:0] result,
  input  logic              useTwos,
  output logic              sdout
);
  logic [DATA_W-1:0] shreg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shreg <= '0;
    else if (strobe.load)  shreg <= {result[DATA_W-1] ^ useTwos, result[DATA_W-2:0]};
    else if (strobe.shift) shreg <= {shreg[DATA_W-2:0], strobe.shiftIn};
  end

  assign sdout = strobe.outEn & shreg[DATA_W-1];

  // R4: a captured word shows its (possibly inverted) MSB once enabled
  p_load_msb_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load && strobe.outEn |=> (sdout == ($past(result[DATA_W-1] ^ useTwos) & strobe.outEn)));
endmodule

// File: rtl/sar_serial_port.sv
module sar_serial_port
  import sps_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int SCLK_HALF = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              convStart,
  input  logic              convDone,
  input  logic [DATA_W-1:0] result,
  input  logic              useTwos,
  input  logic              masterMode,
  input  logic              invSclk,
  input  logic              invSync,
  input  logic              sdinRdc,
  input  logic              csN,
  input  logic              rdN,
  input  logic              sclkIn,
  output logic              sclkOut,
  output logic              sdout,
  output logic              syncOut,
  output logic              busy,
  output logic              rdError
);
  spsStrobe_t strobe;

  sps_ctrl #(.DATA_W(DATA_W), .SCLK_HALF(SCLK_HALF)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .convStart  (convStart),
    .convDone   (convDone),
    .masterMode (masterMode),
    .invSclk    (invSclk),
    .invSync    (invSync),
    .sclkIn     (sclkIn),
    .csN        (csN),
    .rdN        (rdN),
    .sdinRdc    (sdinRdc),
    .strobe     (strobe),
    .busy       (busy),
    .sclkOut    (sclkOut),
    .syncOut    (syncOut),
    .rdError    (rdError)
  );

  sps_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .result  (result),
    .useTwos (useTwos),
    .sdout   (sdout)
  );
endmodule

// File: tb/sar_serial_port_tb_top.sv
`timescale 1ns/1ps
module sar_serial_port_tb_top;
  localparam int HALF = 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic convStart = 0, convDone = 0, useTwos = 0, masterMode = 0;
  logic invSclk = 0, invSync = 0, sdinRdc = 0, csN = 1, rdN = 1, sclkIn = 0;
  logic [15:0] result = '0;
  logic sclkOut, sdout, syncOut, busy, rdError;
  int checks = 0, errors = 0, riseCnt = 0, errCnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sar_serial_port #(.DATA_W(16), .SCLK_HALF(HALF)) dut_i (
    .clk(clk), .rstN(rstN), .convStart(convStart), .convDone(convDone), .result(result),
    .useTwos(useTwos), .masterMode(masterMode), .invSclk(invSclk), .invSync(invSync),
    .sdinRdc(sdinRdc), .csN(csN), .rdN(rdN), .sclkIn(sclkIn), .sclkOut(sclkOut),
    .sdout(sdout), .syncOut(syncOut), .busy(busy), .rdError(rdError)
  );

  always @(posedge sclkOut) riseCnt++;
  always @(negedge clk) if (rdError) errCnt++;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] fmt(input logic [15:0] d, input logic twos);
    return {d[15] ^ twos, d[14:0]};
  endfunction

  // conversion stub; R2 checks on busy
  task automatic convert(input logic [15:0] val, input int doneDelay);
    @(negedge clk); result = val; convStart = 1;
    @(negedge clk); convStart = 0;
    chk("R2", "busy after start", busy, 1);
    waitClk(doneDelay);
    convDone = 1;
    @(negedge clk); convDone = 0;
    chk("R2", "busy after done", busy, 0);
  endtask

  task automatic setSclk(input logic v);
    sclkIn = v; waitClk(6);
  endtask

  task automatic t_reset;
    chk("R1", "busy", busy, 0);
    chk("R1", "sdout", sdout, 0);
    chk("R1", "sclkOut", sclkOut, 0);
    chk("R1", "rdError", rdError, 0);
    chk("R1", "syncOut", syncOut, invSync);
  endtask

  task automatic t_gating;
    masterMode = 0; invSclk = 0; useTwos = 0; csN = 1; rdN = 1; waitClk(6);
    convert(16'hA5C3, 5);
    for (int i = 0; i < 4; i++) begin setSclk(1); setSclk(0); end // cs high: ignored
    rdN = 1; csN = 0; waitClk(6);
    chk("R3", "sdout with rd high", sdout, 0);
    rdN = 0; waitClk(6);
    chk("R3", "msb kept after gated edges", sdout, 1);
    setSclk(1);
    chk("R3", "bit14 after first enabled edge", sdout, 0);
    setSclk(0);
    csN = 1; rdN = 1; waitClk(6);
    chk("R3", "sdout with cs high", sdout, 0);
  endtask

  task automatic t_slave(input logic inv, input logic twos, input logic [15:0] d, input logic [3:0] chain);
    logic [15:0] w;
    logic idle;
    w = fmt(d, twos); idle = inv;
    masterMode = 0; invSclk = inv; useTwos = twos; csN = 1; rdN = 1;
    setSclk(idle);
    convert(d, 4);
    csN = 0; rdN = 0; waitClk(6);
    for (int k = 0; k < 20; k++) begin
      if (k < 16) chk(inv ? "R5" : "R4", "slave data bit", sdout, w[15-k]);
      else        chk("R6", "chained bit", sdout, chain[k-16]);
      sdinRdc = (k < 4) ? chain[k] : 1'b0;
      waitClk(6);
      setSclk(~idle);
      setSclk(idle);
    end
    sdinRdc = 0; csN = 1; rdN = 1; waitClk(6);
  endtask

  task automatic t_overrun;
    int e0;
    masterMode = 0; invSclk = 0; useTwos = 0; csN = 1; rdN = 1;
    setSclk(0);
    convert(16'h1234, 4);
    csN = 0; rdN = 0; waitClk(6);
    for (int i = 0; i < 5; i++) begin setSclk(1); setSclk(0); end
    e0 = errCnt;
    convert(16'hC0DE, 4);
    waitClk(3);
    chk("R7", "one error clock", errCnt - e0, 1);
    chk("R7", "new msb", sdout, 1);
    for (int k = 1; k < 16; k++) begin
      setSclk(1); setSclk(0);
      chk("R7", "new word bit", sdout, 16'hC0DE >> (15 - k) & 1);
    end
    setSclk(1); setSclk(0);
    e0 = errCnt;
    convert(16'h0F0F, 4);
    waitClk(3);
    chk("R7", "no error after full read", errCnt - e0, 0);
    csN = 1; rdN = 1; waitClk(6);
  endtask

  task automatic capture(input logic [15:0] w, input logic inv);
    realtime t0, t1;
    t0 = 0; t1 = 0;
    for (int k = 0; k < 16; k++) begin
      @(posedge sclkOut); #1;
      if (k == 0) t0 = $realtime;
      if (k == 1) t1 = $realtime;
      chk("R8", "master bit", sdout, w[15-k]);
      chk("R9", "sync active", syncOut, !inv);
    end
    chk("R8", "sclk period ns", int'(t1 - t0), 2 * HALF * 4);
  endtask

  task automatic t_master(input logic inv, input logic twos);
    int r0;
    masterMode = 1; invSync = inv; useTwos = twos; sdinRdc = 0; csN = 0; rdN = 0;
    waitClk(8);
    chk("R9", "sync idle", syncOut, inv);
    r0 = riseCnt;
    fork
      convert(16'h8E71, 20);
      capture(fmt(16'h8E71, twos), inv);
    join
    waitClk(10);
    chk("R8", "rises per frame", riseCnt - r0, 16);
    chk("R8", "sclk idle low", sclkOut, 0);
    chk("R9", "sync inactive after frame", syncOut, inv);
    // read during conversion
    sdinRdc = 1; waitClk(6);
    convert(16'h3C96, 100);
    waitClk(10);
    r0 = riseCnt;
    fork
      convert(16'h5001, 100);
      capture(fmt(16'h3C96, twos), inv);
    join
    waitClk(10);
    chk("R10", "one frame per conversion", riseCnt - r0, 16);
    sdinRdc = 0; masterMode = 0; csN = 1; rdN = 1; invSync = 0; waitClk(8);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    waitClk(3);
    t_reset;
    rstN = 1; waitClk(4);
    t_gating;
    t_slave(1'b0, 1'b0, 16'hB38D, 4'b1011);
    t_slave(1'b1, 1'b1, 16'h4E27, 4'b0110);
    t_overrun;
    t_master(1'b0, 1'b0);
    t_master(1'b1, 1'b1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule